// File: doc/BRIEF.md
# Hash Block Sequencing Controller

This block is the control front end of a multi-mode hash accelerator. Message data arrives as 32-bit words and is gathered into 64-byte blocks of sixteen words. A block is delivered either under a DMA request, raised while the input buffer can take a new block, or by software that polls an input-ready flag and then writes sixteen words. Each full buffer is copied into a working register space, and a compression pass is started whose length depends on the selected hash mode. The compression datapath is stood in for by a pass timer.

The controller counts finished blocks against a byte length programmed at the start of a hash. When the last block has been compressed it raises an output-ready flag. If the interrupt enable is set, it also drives an active-low interrupt. Padding is produced outside the block: the programmed length must already cover any padding blocks, and any length that is not a multiple of 64 is rounded up to whole blocks.

Top module: `hash_seq_ctrl`

## Requirements
- R1: Words fill the input buffer in write order (word i of a block is the i-th accepted word). One cycle after the sixteenth word, if no pass is running, the buffer is copied to `work_data` with word i at bits [32i+31:32i].
- R2: `in_rdy` is set by an accepted start with a nonzero length, and again at each copy that leaves further blocks to receive. It clears at the clock edge that accepts the first word of the next block, and it is low after the last block has been copied.
- R3: `dma_req` follows `in_rdy` while `cfg_dma_en` is 1 and stays 0 while `cfg_dma_en` is 0.
- R4: `wr_ready` is low when no hash is active, when all blocks of the message have been received, or while the input buffer is full. A full buffer waits until the running pass ends, so the working block is never overwritten before it has been processed.
- R5: A hash needs ceil(`msg_len`/64) blocks. `out_rdy` rises at the edge on which the last pass ends. A zero length sets `out_rdy` at the start edge.
- R6: `hash_mode` is encoded 0=MD5, 1=SHA-1, 2=SHA-224, 3=SHA-256. A pass keeps `pass_busy` high for 80 cycles in mode 1 and for 64 cycles in the other modes.
- R7: With blocks supplied as soon as they are accepted, an N-block hash sets `out_rdy` N*(rounds+1) edges after the edge that accepts the last word of the first block. That is one copy cycle per block on top of the rounds.
- R8: `irq_n` is 0 exactly when `out_rdy` is 1 and `cfg_irq_en` is 1, and is 1 otherwise.
- R9: A `clr_done` pulse clears `out_rdy` at the next edge, which also releases `irq_n`. An accepted start clears it as well.
- R10: A start pulse while a hash is active is ignored. Mode and length are sampled only at an accepted start, so a start during a hash changes neither the round count nor the block count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dma_en | input | 1 | Request blocks through `dma_req` |
| cfg_irq_en | input | 1 | Drive `irq_n` on completion |
| hash_start | input | 1 | Begin a new hash (pulse) |
| hash_mode | input | 2 | Hash mode, sampled at start |
| msg_len | input | LEN_W | Message length in bytes, sampled at start |
| wr_valid | input | 1 | Word write strobe |
| wr_data | input | WORD_W | Word to write |
| wr_ready | output | 1 | Word is accepted this cycle when high |
| clr_done | input | 1 | Write-one-to-clear of the output-ready flag |
| in_rdy | output | 1 | Input buffer free for the next block |
| out_rdy | output | 1 | Hash complete |
| dma_req | output | 1 | Request for the next block |
| irq_n | output | 1 | Completion interrupt, active low |
| pass_busy | output | 1 | Compression pass running |
| work_data | output | WORDS*WORD_W | Working block handed to the datapath |

## Verification
The bench builds the block with its default parameters: sixteen 32-bit words, a 16-bit length, and 80 and 64 rounds. A single block is cheap to supply, so the bench sweeps all four modes against one-, two- and three-block messages, toggling DMA and interrupt enables and using lengths that fall short of a block boundary. This puts exact completion times, summed busy cycles and the final working-block contents within reach. Directed cases cover a zero length, a 65-byte message, a buffer held full behind a running pass, and a start pulse issued mid-hash.

// File: rtl/hash_seq_pkg.sv
package hash_seq_pkg;
   typedef enum logic [1:0] {
      HM_MD5    = 2'd0,
      HM_SHA1   = 2'd1,
      HM_SHA224 = 2'd2,
      HM_SHA256 = 2'd3
   } hash_mode_e;
endpackage

// File: rtl/hseq_collect.sv
// Input buffer: gathers WORDS words, then reports full until taken.
module hseq_collect #(
   parameter int WORDS  = 16,
   parameter int WORD_W = 32,
   parameter int IDX_W  = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic                    wr_en,
   input  logic [WORD_W-1:0]       wr_data,
   input  logic                    take,
   output logic                    full,
   output logic [IDX_W-1:0]        word_idx,
   output logic [WORDS*WORD_W-1:0] buf_flat
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

   if (WORDS < 2) begin : g_bad_words
      $error("hseq_collect: WORDS must be at least 2");
   end

   logic [IDX_W-1:0] idx_q;
   logic             full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         full_q <= 1'b0;
      end else if (flush) begin
         idx_q  <= '0;
         full_q <= 1'b0;
      end else begin
         if (take) full_q <= 1'b0;
         if (wr_en) begin
            if (idx_q == LAST_IDX) begin
               idx_q  <= '0;
               full_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
      logic [WORD_W-1:0] w_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              w_q <= '0;
         else if (wr_en && idx_q == IDX_W'(gi))   w_q <= wr_data;
      end
      assign buf_flat[gi*WORD_W +: WORD_W] = w_q;
   end

   assign full     = full_q;
   assign word_idx = idx_q;

   // R4: a word is never written into a buffer that is waiting to be copied
   p_no_fill_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full_q);
   // R1: only a complete block is handed on
   p_take_needs_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (full_q && idx_q == '0));
endmodule

// File: rtl/hseq_pass.sv
// Working storage and pass timer standing in for the compression rounds.
module hseq_pass #(
   parameter int WORDS  = 16,
   parameter int WORD_W = 32,
   parameter int CNT_W  = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [CNT_W-1:0]        rounds,
   input  logic [WORDS*WORD_W-1:0] din,
   output logic                    busy,
   output logic                    finish,
   output logic [WORDS*WORD_W-1:0] dout
);
   logic [CNT_W-1:0]        cnt_q;
   logic [WORDS*WORD_W-1:0] work_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         work_q <= '0;
      end else if (load) begin
         cnt_q  <= rounds;
         work_q <= din;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy   = (cnt_q != '0);
   assign finish = (cnt_q == CNT_W'(1));
   assign dout   = work_q;

   // R4: working storage is reloaded only when no pass is running
   p_load_only_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (cnt_q == '0));
   // R6: a pass starts with the round count selected for the hash
   p_count_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(rounds)));
   // R4: the working block holds still while a pass runs
   p_work_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) |=> $stable(work_q));
endmodule

// File: rtl/hseq_fsm.sv
// Sequencer: start, block accounting, ready flags and completion.
module hseq_fsm
   import hash_seq_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int BLK_SH  = 6,
   parameter int CNT_W   = 7,
   parameter int R_LONG  = 80,
   parameter int R_SHORT = 64,
   parameter int IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       mode_in,
   input  logic [LEN_W-1:0] len,
   input  logic             wr_valid,
   input  logic             buf_full,
   input  logic [IDX_W-1:0] word_idx,
   input  logic             pass_busy,
   input  logic             pass_finish,
   input  logic             clr_out,
   output logic             wr_ready,
   output logic             take,
   output logic             flush,
   output logic [CNT_W-1:0] rounds,
   output logic             in_rdy,
   output logic             out_rdy
);
   localparam int BLK_CW = LEN_W - BLK_SH + 1;
   localparam logic [BLK_CW-1:0] ONE_B = BLK_CW'(1);

   if (LEN_W <= BLK_SH) begin : g_bad_len
      $error("hseq_fsm: LEN_W must exceed the block byte shift");
   end
   if (R_LONG < 1 || R_SHORT < 1) begin : g_bad_rounds
      $error("hseq_fsm: round counts must be positive");
   end

   logic [LEN_W:0]    len_ext;
   logic [BLK_CW-1:0] need_c;
   logic [BLK_CW-1:0] need_q, blk_in_q, blk_done_q, blk_in_nx, blk_done_nx;
   logic [CNT_W-1:0]  rounds_q;
   logic              active_q, in_rdy_q, out_rdy_q;
   logic              start_ok, accept, last_done;

   assign len_ext     = {1'b0, len} + (LEN_W+1)'((1 << BLK_SH) - 1);
   assign need_c      = len_ext[LEN_W:BLK_SH];
   assign start_ok    = start && !active_q;
   assign wr_ready    = active_q && !buf_full && (blk_in_q < need_q);
   assign accept      = wr_valid && wr_ready;
   assign take        = active_q && buf_full && !pass_busy;
   assign flush       = start_ok;
   assign blk_in_nx   = blk_in_q + ONE_B;
   assign blk_done_nx = blk_done_q + ONE_B;
   assign last_done   = active_q && pass_finish && (blk_done_nx == need_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         need_q     <= '0;
         blk_in_q   <= '0;
         blk_done_q <= '0;
         rounds_q   <= '0;
         in_rdy_q   <= 1'b0;
         out_rdy_q  <= 1'b0;
      end else if (start_ok) begin
         need_q     <= need_c;
         blk_in_q   <= '0;
         blk_done_q <= '0;
         rounds_q   <= (mode_in == HM_SHA1) ? CNT_W'(R_LONG) : CNT_W'(R_SHORT);
         active_q   <= (need_c != '0);
         in_rdy_q   <= (need_c != '0);
         out_rdy_q  <= (need_c == '0);
      end else begin
         if (accept && word_idx == '0) in_rdy_q <= 1'b0;
         if (take) begin
            blk_in_q <= blk_in_nx;
            if (blk_in_nx < need_q) in_rdy_q <= 1'b1;
         end
         if (active_q && pass_finish) blk_done_q <= blk_done_nx;
         if (last_done) begin
            active_q  <= 1'b0;
            out_rdy_q <= 1'b1;
         end else if (clr_out) begin
            out_rdy_q <= 1'b0;
         end
      end
   end

   assign rounds  = rounds_q;
   assign in_rdy  = in_rdy_q;
   assign out_rdy = out_rdy_q;

   // R2: the first word of a block withdraws the ready flag
   p_first_word_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && word_idx == '0) |=> !in_rdy_q);
   // R5: the end of the final pass marks completion
   p_last_pass_sets_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && pass_finish && blk_done_nx == need_q) |=> out_rdy_q);
   // R10: a start during an active hash leaves the sampled mode alone
   p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && active_q) |=> $stable(rounds_q));
   // R4: no more blocks are copied than the message needs
   p_block_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (blk_in_q < need_q));
endmodule

// File: rtl/hash_seq_ctrl.sv
module hash_seq_ctrl #(
   parameter int WORD_W       = 32,
   parameter int WORDS        = 16,
   parameter int LEN_W        = 16,
   parameter int ROUNDS_LONG  = 80,
   parameter int ROUNDS_SHORT = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_dma_en,
   input  logic                    cfg_irq_en,
   input  logic                    hash_start,
   input  logic [1:0]              hash_mode,
   input  logic [LEN_W-1:0]        msg_len,
   input  logic                    wr_valid,
   input  logic [WORD_W-1:0]       wr_data,
   output logic                    wr_ready,
   input  logic                    clr_done,
   output logic                    in_rdy,
   output logic                    out_rdy,
   output logic                    dma_req,
   output logic                    irq_n,
   output logic                    pass_busy,
   output logic [WORDS*WORD_W-1:0] work_data
);
   localparam int BLK_BYTES = WORDS * WORD_W / 8;
   localparam int BLK_SH    = $clog2(BLK_BYTES);
   localparam int R_MAX     = (ROUNDS_LONG > ROUNDS_SHORT) ? ROUNDS_LONG : ROUNDS_SHORT;
   localparam int CNT_W     = $clog2(R_MAX + 1);
   localparam int IDX_W     = $clog2(WORDS);

   if ((WORD_W % 8) != 0 || (1 << BLK_SH) != BLK_BYTES) begin : g_bad_block
      $error("hash_seq_ctrl: block size must be a power-of-two byte count");
   end

   logic                    wr_en, take, flush, buf_full, finish;
   logic [IDX_W-1:0]        word_idx;
   logic [CNT_W-1:0]        rounds;
   logic [WORDS*WORD_W-1:0] buf_flat;

   assign wr_en = wr_valid && wr_ready;

   hseq_collect #(.WORDS(WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) collect_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
      .take(take), .full(buf_full), .word_idx(word_idx), .buf_flat(buf_flat)
   );

   hseq_pass #(.WORDS(WORDS), .WORD_W(WORD_W), .CNT_W(CNT_W)) pass_i (
      .clk(clk), .rst_n(rst_n), .load(take), .rounds(rounds), .din(buf_flat),
      .busy(pass_busy), .finish(finish), .dout(work_data)
   );

   hseq_fsm #(.LEN_W(LEN_W), .BLK_SH(BLK_SH), .CNT_W(CNT_W), .R_LONG(ROUNDS_LONG),
              .R_SHORT(ROUNDS_SHORT), .IDX_W(IDX_W)) fsm_i (
      .clk(clk), .rst_n(rst_n), .start(hash_start), .mode_in(hash_mode), .len(msg_len),
      .wr_valid(wr_valid), .buf_full(buf_full), .word_idx(word_idx),
      .pass_busy(pass_busy), .pass_finish(finish), .clr_out(clr_done),
      .wr_ready(wr_ready), .take(take), .flush(flush), .rounds(rounds),
      .in_rdy(in_rdy), .out_rdy(out_rdy)
   );

   assign dma_req = cfg_dma_en & in_rdy;
   assign irq_n   = ~(cfg_irq_en & out_rdy);

   // R8: the interrupt is asserted only alongside completion
   p_irq_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (out_rdy && cfg_irq_en));
   // R9: a clear with no completion pending leaves the flag low
   p_clear_drops_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_done && !pass_busy && !hash_start) |=> !out_rdy);
endmodule

// File: tb/hash_seq_ctrl_tb_top.sv
module hash_seq_ctrl_tb_top;
   localparam int WW = 32;
   localparam int NW = 16;
   localparam int LW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_dma_en = 1'b0, cfg_irq_en = 1'b0, hash_start = 1'b0, wr_valid = 1'b0, clr_done = 1'b0;
   logic [1:0] hash_mode = 2'd0;
   logic [LW-1:0] msg_len = '0;
   logic [WW-1:0] wr_data = '0;
   logic wr_ready, in_rdy, out_rdy, dma_req, irq_n, pass_busy;
   logic [NW*WW-1:0] work_data;

   int n_chk = 0, n_bad = 0, cyc = 0, busy_seen = 0;

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (pass_busy) busy_seen = busy_seen + 1;

   hash_seq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .cfg_irq_en(cfg_irq_en),
      .hash_start(hash_start), .hash_mode(hash_mode), .msg_len(msg_len),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .clr_done(clr_done),
      .in_rdy(in_rdy), .out_rdy(out_rdy), .dma_req(dma_req), .irq_n(irq_n),
      .pass_busy(pass_busy), .work_data(work_data)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic do_start(input int mode, input int len);
      @(negedge clk);
      hash_mode = 2'(mode); msg_len = LW'(len); hash_start = 1'b1;
      @(negedge clk);
      hash_start = 1'b0;
   endtask

   // Sends one block of words base..base+15; t_last = edge accepting word 16.
   task automatic send_block(input int base, output int t_last);
      t_last = 0;
      for (int k = 0; k < NW; k++) begin
         @(negedge clk);
         if (k == 1) begin
            check(in_rdy == 1'b0, "R2 first word clears in_rdy", in_rdy, 0);
            check(dma_req == 1'b0, "R3 no request mid-block", dma_req, 0);
         end
         wr_valid = 1'b1; wr_data = WW'(base + k);
         for (int w = 0; w < 500 && !wr_ready; w++) @(negedge clk);
         t_last = cyc + 1;
      end
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic wait_done(output int t_done);
      t_done = -1;
      for (int w = 0; w < 2000; w++) begin
         if (out_rdy) begin t_done = cyc; break; end
         @(negedge clk);
      end
   endtask

   // Full hash with blocks supplied back to back.
   task automatic run_hash(input int mode, input int nblk, input int len, input bit dma, input bit irq);
      int rr, t0, tl, td, b0, base;
      rr = (mode == 1) ? 80 : 64;
      base = mode * 4096 + nblk * 256;
      cfg_dma_en = dma; cfg_irq_en = irq;
      do_start(mode, len);
      check(in_rdy == 1'b1, "R2 in_rdy after start", in_rdy, 1);
      check(dma_req == dma, "R3 dma_req follows enable", dma_req, dma);
      check(wr_ready == 1'b1, "R4 ready after start", wr_ready, 1);
      b0 = busy_seen;
      t0 = 0;
      for (int b = 0; b < nblk; b++) begin
         send_block(base + b * NW, tl);
         if (b == 0) t0 = tl;
      end
      wait_done(td);
      check(td - t0 == nblk * (rr + 1), "R7 completion time", td - t0, nblk * (rr + 1));
      check(busy_seen - b0 == nblk * rr, "R6 busy cycles per mode", busy_seen - b0, nblk * rr);
      for (int i = 0; i < NW; i++)
         check(work_data[i*WW +: WW] == WW'(base + (nblk - 1) * NW + i), "R1 working word order",
               work_data[i*WW +: WW], base + (nblk - 1) * NW + i);
      check(in_rdy == 1'b0, "R2 no ready after last block", in_rdy, 0);
      check(wr_ready == 1'b0, "R4 no input after message", wr_ready, 0);
      check(irq_n == !irq, "R8 irq_n on completion", irq_n, !irq);
      @(negedge clk); clr_done = 1'b1;
      @(negedge clk); clr_done = 1'b0;
      check(out_rdy == 1'b0, "R9 clear drops out_rdy", out_rdy, 0);
      check(irq_n == 1'b1, "R9 clear releases irq_n", irq_n, 1);
   endtask

   initial begin
      int ta, tb, td, lens;
      repeat (3) @(negedge clk);
      check(wr_ready == 0 && in_rdy == 0 && out_rdy == 0 && dma_req == 0 && pass_busy == 0,
            "R4 reset state quiet", {wr_ready, in_rdy, out_rdy, dma_req, pass_busy}, 0);
      check(irq_n == 1'b1, "R8 reset irq_n high", irq_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(wr_ready == 1'b0, "R4 idle refuses words", wr_ready, 0);

      for (int m = 0; m < 4; m++)
         for (int nb = 1; nb <= 3; nb++) begin
            lens = nb * 64 - m * 5;
            run_hash(m, nb, lens, bit'((nb + m) % 2), bit'(m < 2));
         end

      // R5: 65 bytes round up to two blocks
      run_hash(2, 2, 65, 1'b1, 1'b1);

      // R5: zero length completes at the start edge
      cfg_irq_en = 1'b1;
      do_start(0, 0);
      check(out_rdy == 1'b1, "R5 zero length done", out_rdy, 1);
      check(in_rdy == 1'b0 && wr_ready == 1'b0, "R5 zero length takes no words", {in_rdy, wr_ready}, 0);
      check(irq_n == 1'b0, "R8 irq on zero length", irq_n, 0);
      @(negedge clk); clr_done = 1'b1;
      @(negedge clk); clr_done = 1'b0;
      check(out_rdy == 1'b0, "R9 clear after zero length", out_rdy, 0);

      // R4: buffer held full behind a running pass
      cfg_dma_en = 1'b1; cfg_irq_en = 1'b0;
      do_start(0, 192);
      send_block(100, ta);
      send_block(200, tb);
      @(negedge clk);
      check(wr_ready == 1'b0, "R4 stall while buffer full", wr_ready, 0);
      check(work_data[0 +: WW] == WW'(100), "R4 working block kept", work_data[0 +: WW], 100);
      check(pass_busy == 1'b1, "R4 pass still running", pass_busy, 1);
      check(in_rdy == 1'b0 && dma_req == 1'b0, "R3 no request while full", {in_rdy, dma_req}, 0);
      send_block(300, tb);
      wait_done(td);
      check(td - ta == 3 * 65, "R7 stalled stream timing", td - ta, 3 * 65);
      check(work_data[0 +: WW] == WW'(300), "R1 last block in working space", work_data[0 +: WW], 300);
      do_start(3, 64);   // start clears out_rdy
      check(out_rdy == 1'b0, "R9 start clears out_rdy", out_rdy, 0);
      send_block(400, ta);
      wait_done(td);
      @(negedge clk); clr_done = 1'b1;
      @(negedge clk); clr_done = 1'b0;

      // R10: start during a hash changes neither mode nor length
      cfg_dma_en = 1'b0;
      do_start(1, 64);
      check(dma_req == 1'b0 && in_rdy == 1'b1, "R3 polled mode no request", {dma_req, in_rdy}, 1);
      do_start(0, 640);
      send_block(500, ta);
      wait_done(td);
      check(td - ta == 81, "R10 mode kept after mid-hash start", td - ta, 81);
      check(wr_ready == 1'b0, "R10 length kept after mid-hash start", wr_ready, 0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule